// File: doc/BRIEF.md
# Sixteen-Bit Instruction Decoder

This block turns one 16-bit instruction word of a small eight-register RISC pipeline into the control, register-index and immediate values that the execute, memory and write-back stages need. It is purely combinational. The decode stage places it after the instruction register and latches its outputs into the next pipeline register. The ALU, the register file and the data memory are outside this block.

The three top bits select the instruction class. Class 000 is register-to-register, and a 4-bit function code in bits [3:0] picks the operation, which includes an indirect jump through a register. The other seven classes are add-immediate, load, store, branch-if-equal, branch-if-not-equal, absolute jump, and jump-and-link. Jump-and-link always writes the return address PC+2 into register 7. The block presents the 7-bit offset sign-extended to the full data width. It presents the 13-bit jump target zero-extended.

Top module: `instr_decoder`

## Requirements
- R1: Source index `rs_o` is bits [12:10], second index `rt_o` is bits [9:7] and destination index `rd_o` is bits [6:4] of the word, for every opcode.
- R2: `imm_o` is bits [6:0] sign-extended to 16 bits (bit 6 copied into bits [15:7]), for every opcode.
- R3: `jtarget_o` is bits [12:0] with three zero bits above, for every opcode.
- R4: Opcode 000 with function 0000 to 0111 (add, sub, and, or, shift left, shift right logical, shift right arithmetic, set-less-than) gives `reg_we_o`=1, `dst_sel_o`=00 (rd), `alu_src_o`=0, `wb_sel_o`=00 (ALU) and `alu_fn_o` equal to the function code.
- R5: Opcode 000 with function 1000 (register jump) gives `jmp_kind_o`=10 (target from rs), `reg_we_o`=0 and `alu_fn_o`=0000.
- R6: Opcode 000 with function 1001 to 1111 has no effect: every control output, including `alu_fn_o`, is zero.
- R7: Opcode 001 (add immediate) gives `reg_we_o`=1, `dst_sel_o`=01 (rt), `alu_src_o`=1 (immediate) and `alu_fn_o`=0000 (add).
- R8: Opcode 100 (load) gives `reg_we_o`=1, `dst_sel_o`=01, `alu_src_o`=1, `mem_rd_o`=1, `wb_sel_o`=01 (memory) and `alu_fn_o`=0000.
- R9: Opcode 101 (store) gives `mem_wr_o`=1, `alu_src_o`=1, `alu_fn_o`=0000 and no register write. `mem_rd_o` and `mem_wr_o` are never both 1.
- R10: Opcode 110 gives `br_kind_o`=01 (taken on equal) and opcode 111 gives `br_kind_o`=10 (taken on not equal). Both give `alu_fn_o`=0001 (subtract), `alu_src_o`=0 and no register write.
- R11: Opcode 010 gives `jmp_kind_o`=01 (absolute target) with no write. Opcode 011 gives `jmp_kind_o`=01, `reg_we_o`=1, `dst_sel_o`=10 (r7) and `wb_sel_o`=10 (PC+2).
- R12: Every control output that a requirement does not name for an instruction is zero for that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word |
| reg_we_o | output | 1 | Register file write enable |
| dst_sel_o | output | 2 | Destination select: 00 rd, 01 rt, 10 r7 |
| alu_src_o | output | 1 | Second ALU operand: 0 register, 1 immediate |
| mem_rd_o | output | 1 | Data memory read enable |
| mem_wr_o | output | 1 | Data memory write enable |
| br_kind_o | output | 2 | Branch type: 00 none, 01 equal, 10 not equal |
| jmp_kind_o | output | 2 | Jump type: 00 none, 01 absolute, 10 register |
| wb_sel_o | output | 2 | Write-back source: 00 ALU, 01 memory, 10 PC+2 |
| alu_fn_o | output | 4 | ALU function code |
| rs_o | output | 3 | First source register index |
| rt_o | output | 3 | Second source / immediate destination index |
| rd_o | output | 3 | Register-type destination index |
| imm_o | output | 16 | Sign-extended 7-bit offset |
| jtarget_o | output | 16 | Zero-extended 13-bit jump target |

## Verification
The bench targets four cases. Offsets with bit 6 set must come out negative: a decoder that zero-extended them would send backward branches forward. Targets with bit 12 set must stay positive: a decoder that sign-extended them would jump into the top of memory. The register jump and the seven unused function codes share opcode 000 with the ALU operations. A decoder that decoded only the opcode there would write garbage into rd or miss the jump. The bench also checks that jump-and-link names r7 with the PC+2 source, and that store and the branches never raise the write enable. A decoder that got either wrong would corrupt registers silently. After the directed cases, the bench sweeps every 16-bit word against its model.

// File: rtl/idec_pkg.sv
// Package: shared encodings for the instruction decoder.
// Assumes a 3-bit major opcode in the top bits of the word.
package idec_pkg;

    typedef enum logic [2:0] {
        OP_REG   = 3'b000,
        OP_ADDI  = 3'b001,
        OP_JMP   = 3'b010,
        OP_JAL   = 3'b011,
        OP_LOAD  = 3'b100,
        OP_STORE = 3'b101,
        OP_BEQ   = 3'b110,
        OP_BNE   = 3'b111
    } opcode_e;

    typedef enum logic [1:0] {
        DST_RD   = 2'b00,
        DST_RT   = 2'b01,
        DST_LINK = 2'b10
    } dst_e;

    typedef enum logic [1:0] {
        BR_NONE = 2'b00,
        BR_EQ   = 2'b01,
        BR_NE   = 2'b10
    } br_e;

    typedef enum logic [1:0] {
        JMP_NONE = 2'b00,
        JMP_ABS  = 2'b01,
        JMP_REG  = 2'b10
    } jmp_e;

    typedef enum logic [1:0] {
        WB_ALU  = 2'b00,
        WB_MEM  = 2'b01,
        WB_LINK = 2'b10
    } wb_e;

    localparam int FN_W = 4;

    localparam logic [FN_W-1:0] FN_ADD    = 4'b0000;
    localparam logic [FN_W-1:0] FN_SUB    = 4'b0001;
    localparam logic [FN_W-1:0] FN_LASTOP = 4'b0111;
    localparam logic [FN_W-1:0] FN_JREG   = 4'b1000;

    // Bundle of control outputs produced by the opcode decoder.
    typedef struct packed {
        logic            reg_we;
        dst_e            dst;
        logic            alu_src;
        logic            mem_rd;
        logic            mem_wr;
        br_e             br;
        jmp_e            jmp;
        wb_e             wb;
        logic [FN_W-1:0] alu_fn;
    } ctrl_t;

endpackage

// File: rtl/idec_fields.sv
// Module: idec_fields
// Splits the instruction word into opcode, register indices and
// function code, and builds the two immediates.
// Assumes the opcode sits in the top OP_W bits and the indices follow it
// in the order rs, rt, rd. The function code and the offset are right-aligned.
module idec_fields #(
    parameter int WORD_W = 16,
    parameter int OP_W   = 3,
    parameter int IDX_W  = 3,
    parameter int FN_W   = 4,
    parameter int OFF_W  = 7,
    parameter int DATA_W = 16
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [OP_W-1:0]   op_o,
    output logic [IDX_W-1:0]  rs_o,
    output logic [IDX_W-1:0]  rt_o,
    output logic [IDX_W-1:0]  rd_o,
    output logic [FN_W-1:0]   fn_o,
    output logic [DATA_W-1:0] imm_o,
    output logic [DATA_W-1:0] jt_o
);
    localparam int RS_HI = WORD_W - OP_W - 1;
    localparam int RT_HI = RS_HI - IDX_W;
    localparam int RD_HI = RT_HI - IDX_W;
    localparam int JT_W  = WORD_W - OP_W;

    logic [OFF_W-1:0] off_raw;
    logic [JT_W-1:0]  jt_raw;

    // Purpose: fixed-position field extraction.
    always_comb begin
        op_o    = word_i[WORD_W-1 -: OP_W];
        rs_o    = word_i[RS_HI -: IDX_W];
        rt_o    = word_i[RT_HI -: IDX_W];
        rd_o    = word_i[RD_HI -: IDX_W];
        fn_o    = word_i[FN_W-1:0];
        off_raw = word_i[OFF_W-1:0];
        jt_raw  = word_i[JT_W-1:0];
    end

    // Purpose: widen the offset with its sign bit and the target with zeros.
    always_comb begin
        imm_o = {{(DATA_W-OFF_W){off_raw[OFF_W-1]}}, off_raw};
        jt_o  = {{(DATA_W-JT_W){1'b0}}, jt_raw};
        AST_IMM_SIGN: assert (imm_o[DATA_W-1] == word_i[OFF_W-1]); // R2
        AST_JT_POSITIVE: assert (jt_o[DATA_W-1] == 1'b0);          // R3
    end

endmodule

// File: rtl/idec_rtype.sv
// Module: idec_rtype
// Classifies the register-type function code. It reports whether the code
// is an ALU operation that writes rd, the register jump, or unused.
// Assumes ALU operations occupy codes 0 up to FN_LASTOP.
module idec_rtype
    import idec_pkg::*;
(
    input  logic [FN_W-1:0] fn_i,
    output logic            alu_op_o,
    output logic            jreg_o,
    output logic [FN_W-1:0] alu_fn_o
);
    // Purpose: sort the function code into operation, jump or unused.
    always_comb begin
        alu_op_o = (fn_i <= FN_LASTOP);
        jreg_o   = (fn_i == FN_JREG);
        alu_fn_o = alu_op_o ? fn_i : FN_ADD;
        AST_RTYPE_CLASS: assert (!(alu_op_o && jreg_o)); // R5
    end

endmodule

// File: rtl/idec_main.sv
// Module: idec_main
// Major opcode decoder. It produces the full control bundle and uses the
// register-type classification only for opcode 000.
// Assumes every output not set for an instruction stays at zero.
module idec_main
    import idec_pkg::*;
#(
    parameter int OP_W = 3
) (
    input  logic [OP_W-1:0] op_i,
    input  logic            r_alu_i,
    input  logic            r_jreg_i,
    input  logic [FN_W-1:0] r_fn_i,
    output ctrl_t           ctrl_o
);
    // Purpose: per-opcode control table with an all-zero default.
    always_comb begin
        ctrl_o         = '0;
        ctrl_o.dst     = DST_RD;
        ctrl_o.br      = BR_NONE;
        ctrl_o.jmp     = JMP_NONE;
        ctrl_o.wb      = WB_ALU;
        ctrl_o.alu_fn  = FN_ADD;
        unique case (opcode_e'(op_i))
            OP_REG: begin
                if (r_alu_i) begin
                    ctrl_o.reg_we = 1'b1;
                    ctrl_o.alu_fn = r_fn_i;
                end else if (r_jreg_i) begin
                    ctrl_o.jmp = JMP_REG;
                end
            end
            OP_ADDI: begin
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.dst     = DST_RT;
                ctrl_o.alu_src = 1'b1;
            end
            OP_JMP: begin
                ctrl_o.jmp = JMP_ABS;
            end
            OP_JAL: begin
                ctrl_o.jmp    = JMP_ABS;
                ctrl_o.reg_we = 1'b1;
                ctrl_o.dst    = DST_LINK;
                ctrl_o.wb     = WB_LINK;
            end
            OP_LOAD: begin
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.dst     = DST_RT;
                ctrl_o.alu_src = 1'b1;
                ctrl_o.mem_rd  = 1'b1;
                ctrl_o.wb      = WB_MEM;
            end
            OP_STORE: begin
                ctrl_o.alu_src = 1'b1;
                ctrl_o.mem_wr  = 1'b1;
            end
            OP_BEQ: begin
                ctrl_o.br     = BR_EQ;
                ctrl_o.alu_fn = FN_SUB;
            end
            OP_BNE: begin
                ctrl_o.br     = BR_NE;
                ctrl_o.alu_fn = FN_SUB;
            end
            default: ;
        endcase
        AST_MEM_EXCL: assert (!(ctrl_o.mem_rd && ctrl_o.mem_wr));         // R9
        AST_LINK_R7: assert ((ctrl_o.wb != WB_LINK) || (ctrl_o.dst == DST_LINK && ctrl_o.reg_we)); // R11
    end

endmodule

// File: rtl/instr_decoder.sv
// Module: instr_decoder (top)
// Combinational decode of one instruction word. It splits the word into
// fields, classifies the function code and builds the control bundle.
// Assumes the caller registers the outputs; there is no state here.
module instr_decoder
    import idec_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 7,
    parameter int DATA_W = 16
) (
    input  logic [WORD_W-1:0] instr_i,
    output logic              reg_we_o,
    output logic [1:0]        dst_sel_o,
    output logic              alu_src_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [1:0]        br_kind_o,
    output logic [1:0]        jmp_kind_o,
    output logic [1:0]        wb_sel_o,
    output logic [FN_W-1:0]   alu_fn_o,
    output logic [IDX_W-1:0]  rs_o,
    output logic [IDX_W-1:0]  rt_o,
    output logic [IDX_W-1:0]  rd_o,
    output logic [DATA_W-1:0] imm_o,
    output logic [DATA_W-1:0] jtarget_o
);
    localparam int OP_W = 3;

    logic [OP_W-1:0] op;
    logic [FN_W-1:0] fn;
    logic            r_alu;
    logic            r_jreg;
    logic [FN_W-1:0] r_fn;
    ctrl_t           ctrl;

    idec_fields #(
        .WORD_W (WORD_W),
        .OP_W   (OP_W),
        .IDX_W  (IDX_W),
        .FN_W   (FN_W),
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) u_fields (
        .word_i (instr_i),
        .op_o   (op),
        .rs_o   (rs_o),
        .rt_o   (rt_o),
        .rd_o   (rd_o),
        .fn_o   (fn),
        .imm_o  (imm_o),
        .jt_o   (jtarget_o)
    );

    idec_rtype u_rtype (
        .fn_i     (fn),
        .alu_op_o (r_alu),
        .jreg_o   (r_jreg),
        .alu_fn_o (r_fn)
    );

    idec_main #(
        .OP_W (OP_W)
    ) u_main (
        .op_i     (op),
        .r_alu_i  (r_alu),
        .r_jreg_i (r_jreg),
        .r_fn_i   (r_fn),
        .ctrl_o   (ctrl)
    );

    // Purpose: flatten the control bundle onto plain ports.
    always_comb begin
        reg_we_o   = ctrl.reg_we;
        dst_sel_o  = ctrl.dst;
        alu_src_o  = ctrl.alu_src;
        mem_rd_o   = ctrl.mem_rd;
        mem_wr_o   = ctrl.mem_wr;
        br_kind_o  = ctrl.br;
        jmp_kind_o = ctrl.jmp;
        wb_sel_o   = ctrl.wb;
        alu_fn_o   = ctrl.alu_fn;
    end

    // Purpose: cross-block consistency of the decoded controls.
    always_comb begin
        AST_JR_NO_WRITE: assert ((jmp_kind_o != JMP_REG) || !reg_we_o);        // R5
        AST_BRANCH_NOT_JUMP: assert ((br_kind_o == BR_NONE) || (jmp_kind_o == JMP_NONE)); // R10
        AST_MEM_USES_IMM: assert (!(mem_rd_o || mem_wr_o) || alu_src_o);       // R8
        AST_STORE_NO_WRITE: assert (!mem_wr_o || !reg_we_o);                   // R9
    end

endmodule

// File: tb/tb_instr_decoder.sv
module tb_instr_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'h0000;

    logic        reg_we, alu_src, mem_rd, mem_wr;
    logic [1:0]  dst_sel, br_kind, jmp_kind, wb_sel;
    logic [3:0]  alu_fn;
    logic [2:0]  rs, rt, rd;
    logic [15:0] imm, jt;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    instr_decoder dut (
        .instr_i    (instr),
        .reg_we_o   (reg_we),
        .dst_sel_o  (dst_sel),
        .alu_src_o  (alu_src),
        .mem_rd_o   (mem_rd),
        .mem_wr_o   (mem_wr),
        .br_kind_o  (br_kind),
        .jmp_kind_o (jmp_kind),
        .wb_sel_o   (wb_sel),
        .alu_fn_o   (alu_fn),
        .rs_o       (rs),
        .rt_o       (rt),
        .rd_o       (rd),
        .imm_o      (imm),
        .jtarget_o  (jt)
    );

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s instr=%h actual=%0h expected=%0h", req, what, instr, act, exp);
        end
    endtask

    // Behavioural model of the requirements; compares every output.
    task automatic compare_all();
        int op, fn, e_we, e_dst, e_src, e_mrd, e_mwr, e_br, e_jmp, e_wb, e_fn, e_imm;
        string tag;
        op = int'(instr[15:13]);
        fn = int'(instr[3:0]);
        e_we = 0; e_dst = 0; e_src = 0; e_mrd = 0; e_mwr = 0;
        e_br = 0; e_jmp = 0; e_wb = 0; e_fn = 0;
        case (op)
            0: begin
                if (fn < 8) begin tag = "R4"; e_we = 1; e_fn = fn; end
                else if (fn == 8) begin tag = "R5"; e_jmp = 2; end
                else tag = "R6";
            end
            1: begin tag = "R7"; e_we = 1; e_dst = 1; e_src = 1; end
            2: begin tag = "R11"; e_jmp = 1; end
            3: begin tag = "R11"; e_jmp = 1; e_we = 1; e_dst = 2; e_wb = 2; end
            4: begin tag = "R8"; e_we = 1; e_dst = 1; e_src = 1; e_mrd = 1; e_wb = 1; end
            5: begin tag = "R9"; e_src = 1; e_mwr = 1; end
            6: begin tag = "R10"; e_br = 1; e_fn = 1; end
            default: begin tag = "R10"; e_br = 2; e_fn = 1; end
        endcase
        e_imm = int'(instr[6:0]);
        if (instr[6]) e_imm = e_imm - 128;
        check(tag, "reg_we", int'(reg_we), e_we);
        check(tag, "dst_sel", int'(dst_sel), e_dst);
        check(tag, "alu_src", int'(alu_src), e_src);
        check(tag, "mem_rd", int'(mem_rd), e_mrd);
        check(tag, "mem_wr", int'(mem_wr), e_mwr);
        check(tag, "br_kind", int'(br_kind), e_br);
        check(tag, "jmp_kind", int'(jmp_kind), e_jmp);
        check(tag, "wb_sel", int'(wb_sel), e_wb);
        check(tag, "alu_fn", int'(alu_fn), e_fn);
        check("R12", "no_stray_mem", int'(mem_rd & mem_wr), 0);
        check("R1", "rs", int'(rs), int'(instr[12:10]));
        check("R1", "rt", int'(rt), int'(instr[9:7]));
        check("R1", "rd", int'(rd), int'(instr[6:4]));
        check("R2", "imm", int'($signed(imm)), e_imm);
        check("R3", "jtarget", int'(jt), int'(instr[12:0]));
    endtask

    task automatic apply(logic [15:0] w);
        @(posedge clk);
        #1 instr = w;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all();                      // reset state: add r0 (R4)
        #1 rst_n = 1'b1;
        apply(16'b000_001_010_011_0001);    // R4 sub
        apply(16'b000_111_110_101_0110);    // R4 arithmetic shift
        apply(16'b000_111_110_101_0111);    // R4 set-less-than, top op
        apply(16'b000_101_000_000_1000);    // R5 register jump
        apply(16'b000_101_011_111_1001);    // R6 first unused code
        apply(16'b000_111_111_111_1111);    // R6 last unused code
        apply(16'b001_010_011_1000000);     // R7 most negative offset, R2
        apply(16'b001_010_011_0111111);     // R7 most positive offset, R2
        apply(16'b100_001_100_1111111);     // R8 offset -1
        apply(16'b101_110_001_0000001);     // R9 store
        apply(16'b110_001_010_1111110);     // R10 equal, backward
        apply(16'b111_011_100_0000100);     // R10 not equal
        apply(16'b010_1000000000000);       // R11 jump, target bit 12 set, R3
        apply(16'b011_1111111111111);       // R11 link, all-ones target, R3
        apply(16'b011_0000000000000);       // R11 link to zero
        for (int w = 0; w < 65536; w++) apply(16'(w));   // R1..R12 sweep
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule